// File: doc/BRIEF.md
# PC-Relative Conditional Branch Evaluator

This block resolves conditional branch instructions for a 16-bit processor core. Each cycle it looks at an instruction word, the address of that instruction and the four arithmetic status flags. It decides whether the branch is taken and works out the address of the next instruction. The result is registered, so it appears one clock after the inputs are sampled.

A branch-format word carries a 3-bit condition selector and a 10-bit signed offset counted in words. When the branch is taken, the next address is the address after the branch plus twice the offset, wrapped modulo 2^16. When the branch is not taken, or the word is not a branch at all, the next address is simply the following word. The block only reads the flags and has no path that could write them. Fetch and flag generation sit outside it.

Top module: `jmp_unit`

## Requirements
- R1: While rst_ni is low, taken_o is 0 and next_pc_o is 0.
- R2: A word is a branch only when instr_i[15:13] equals 3'b001. For any other word, taken_o is 0 on the next cycle.
- R3: The condition selector is instr_i[12:10]. flags_i bit 0 is carry (C), bit 1 is zero (Z), bit 2 is negative (N) and bit 3 is overflow (V). The codes select the following tests:
  - 000: Z=0
  - 001: Z=1
  - 010: C=0
  - 011: C=1
  - 100: N=1
  - 101: (N xor V)=0
  - 110: (N xor V)=1
  - 111: always taken
- R4: When the branch is taken, next_pc_o equals pc_i + 2 + 2*sext(instr_i[9:0]) modulo 2^16, with bit 0 cleared.
- R5: When the branch is not taken, or the word is not a branch, next_pc_o equals pc_i + 2 modulo 2^16, with bit 0 cleared.
- R6: The offset extremes reach exactly -511 and +512 words from the branch instruction. Offset 0x1FF gives pc_i+1024. Offset 0x200 gives pc_i-1022.
- R7: next_pc_o[0] is always 0.
- R8: Outputs reflect the inputs sampled at the previous rising clock edge, which is a latency of exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| instr_i | input | 16 | Instruction word under evaluation |
| pc_i | input | 16 | Address of the instruction word |
| flags_i | input | 4 | Status flags {V,N,Z,C} |
| taken_o | output | 1 | Branch taken, registered |
| next_pc_o | output | 16 | Address of the next instruction, registered |

## Verification
The assertions assume that every input is stable and known at each rising edge. They also assume that pc_i is word aligned; the R7 check holds regardless. The stimulus drives all inputs at the falling edge. It draws pc_i as an even value. It biases a large share of instruction words toward the branch format so that every condition code meets every flag combination. Directed cases cover the extreme offsets and wrap-around past both ends of the address space.

// File: rtl/jmp_pkg.sv
package jmp_pkg;
  localparam int INSTR_W = 16;
  localparam int COND_W  = 3;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

  typedef enum logic [COND_W-1:0] {
    CC_NZ  = 3'b000,
    CC_Z   = 3'b001,
    CC_NC  = 3'b010,
    CC_C   = 3'b011,
    CC_N   = 3'b100,
    CC_GE  = 3'b101,
    CC_LT  = 3'b110,
    CC_ALW = 3'b111
  } cond_e;
endpackage

// File: rtl/jmp_decode.sv
module jmp_decode
  import jmp_pkg::*;
#(
  parameter int OFFS_W = 10
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic               is_jmp_o,
  output cond_e              cond_o,
  output logic [OFFS_W-1:0]  offs_o
);
  localparam logic [2:0] JMP_TAG = 3'b001;

  assign is_jmp_o = (instr_i[INSTR_W-1 -: 3] == JMP_TAG);
  assign cond_o   = cond_e'(instr_i[OFFS_W +: COND_W]);
  assign offs_o   = instr_i[OFFS_W-1:0];
endmodule

// File: rtl/jmp_cond_eval.sv
module jmp_cond_eval
  import jmp_pkg::*;
(
  input  cond_e  cond_i,
  input  flags_t flags_i,
  output logic   pass_o
);
  always_comb begin
    unique case (cond_i)
      CC_NZ:   pass_o = ~flags_i.z;
      CC_Z:    pass_o =  flags_i.z;
      CC_NC:   pass_o = ~flags_i.c;
      CC_C:    pass_o =  flags_i.c;
      CC_N:    pass_o =  flags_i.n;
      CC_GE:   pass_o = ~(flags_i.n ^ flags_i.v);
      CC_LT:   pass_o =  (flags_i.n ^ flags_i.v);
      default: pass_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/jmp_target_calc.sv
module jmp_target_calc #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 10
) (
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [OFFS_W-1:0] offs_i,
  output logic [ADDR_W-1:0] seq_pc_o,
  output logic [ADDR_W-1:0] tgt_pc_o
);
  localparam int EXT_W = ADDR_W - OFFS_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] offs_ext;
  logic [ADDR_W-1:0] seq_raw;
  logic [ADDR_W-1:0] tgt_raw;

  assign offs_ext = {{EXT_W{offs_i[OFFS_W-1]}}, offs_i};
  assign seq_raw  = pc_i + STEP;
  assign tgt_raw  = seq_raw + (offs_ext << 1);

  // word alignment: bit 0 forced low
  assign seq_pc_o = {seq_raw[ADDR_W-1:1], 1'b0};
  assign tgt_pc_o = {tgt_raw[ADDR_W-1:1], 1'b0};
endmodule

// File: rtl/jmp_unit.sv
module jmp_unit
  import jmp_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [ADDR_W-1:0]  pc_i,
  input  logic [3:0]         flags_i,
  output logic               taken_o,
  output logic [ADDR_W-1:0]  next_pc_o
);
  logic              is_jmp;
  cond_e             cond;
  logic [OFFS_W-1:0] offs;
  logic              pass;
  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] tgt_pc;
  logic              take_d;
  logic [ADDR_W-1:0] npc_d;

  jmp_decode #(.OFFS_W(OFFS_W)) u_dec (
    .instr_i (instr_i),
    .is_jmp_o(is_jmp),
    .cond_o  (cond),
    .offs_o  (offs)
  );

  jmp_cond_eval u_cond (
    .cond_i (cond),
    .flags_i(flags_t'(flags_i)),
    .pass_o (pass)
  );

  jmp_target_calc #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_tgt (
    .pc_i    (pc_i),
    .offs_i  (offs),
    .seq_pc_o(seq_pc),
    .tgt_pc_o(tgt_pc)
  );

  assign take_d = is_jmp & pass;
  assign npc_d  = take_d ? tgt_pc : seq_pc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      taken_o   <= 1'b0;
      next_pc_o <= '0;
    end else begin
      taken_o   <= take_d;
      next_pc_o <= npc_d;
    end
  end

  // R7
  even_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    next_pc_o[0] == 1'b0);

  // R2
  non_jmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[15:13] != 3'b001) |=> !taken_o);

  // R3
  always_jmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[15:10] == 6'b001111) |=> taken_o);

  // R5
  seq_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[15:13] != 3'b001) |=>
      next_pc_o == (($past(pc_i) + ADDR_W'(2)) & ~ADDR_W'(1)));

  // R3
  z_cond_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[15:10] == 6'b001001 && !flags_i[1]) |=> !taken_o);
endmodule

// File: tb/jmp_unit_test.sv
`timescale 1ns/1ps
module jmp_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc = '0;
  logic [3:0]  flags = '0;
  logic        taken;
  logic [15:0] npc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  jmp_unit uut (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .instr_i  (instr),
    .pc_i     (pc),
    .flags_i  (flags),
    .taken_o  (taken),
    .next_pc_o(npc)
  );

  function automatic bit exp_take(input logic [15:0] w, input logic [3:0] f);
    bit c = f[0], z = f[1], n = f[2], v = f[3];
    if (w[15:13] != 3'b001) return 1'b0;
    case (w[12:10])
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !c;
      3'd3: return c;
      3'd4: return n;
      3'd5: return (n == v);
      3'd6: return (n != v);
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [15:0] exp_pc(input logic [15:0] w, input logic [15:0] p,
                                         input logic [3:0] f);
    int off = int'(w[9:0]);
    int r;
    if (off >= 512) off -= 1024;
    r = int'(p) + 2;
    if (exp_take(w, f)) r += 2 * off;
    return 16'(r) & 16'hFFFE;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, result after next posedge, sample at following negedge
  task automatic apply(input string req, input logic [15:0] w, input logic [15:0] p,
                       input logic [3:0] f);
    instr = w; pc = p; flags = f;
    @(negedge clk);
    chk(req, {15'd0, taken}, {15'd0, exp_take(w, f)});
    chk(req, npc, exp_pc(w, p, f));
  endtask

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    instr = 16'h3FFF; pc = 16'h1234; flags = 4'hF;
    repeat (3) @(negedge clk);
    // R1 reset state with active stimulus
    chk("R1", {15'd0, taken}, 16'd0);
    chk("R1", npc, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R8 one-cycle latency: output follows previous sample, then updates
    instr = 16'h3C05; pc = 16'h0100; flags = 4'h0;
    @(negedge clk);
    instr = 16'h0000; pc = 16'h0200;
    chk("R8", npc, 16'h010C);
    @(negedge clk);
    chk("R8", npc, 16'h0202);

    // R6 extreme offsets
    apply("R6", 16'h3DFF, 16'h4000, 4'h0);
    chk("R6", npc, 16'h4400);
    apply("R6", 16'h3E00, 16'h4000, 4'h0);
    chk("R6", npc, 16'h3C02);
    // R4 wrap across both ends
    apply("R4", 16'h3C10, 16'hFFF0, 4'h0);
    apply("R4", 16'h3FF0, 16'h0004, 4'h0);
    // R5 sequential wrap
    apply("R5", 16'h0000, 16'hFFFE, 4'h0);
    // R7 odd pc still yields even result
    apply("R7", 16'h3C01, 16'h0101, 4'h0);
    chk("R7", {15'd0, npc[0]}, 16'd0);
    // R3 each code against all flag patterns
    for (int cc = 0; cc < 8; cc++)
      for (int f = 0; f < 16; f++)
        apply("R3", {3'b001, 3'(cc), 10'h023}, 16'h8000, 4'(f));
    // R2 non-branch formats
    for (int t = 0; t < 8; t++)
      if (t != 1) apply("R2", {3'(t), 13'h1C55}, 16'h2468, 4'hF);

    // R4 R5 random mix
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] w = 16'($urandom);
      logic [15:0] p = 16'($urandom) & 16'hFFFE;
      if ($urandom_range(3) != 0) w[15:13] = 3'b001;
      apply("R4", w, p, 4'($urandom));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule